// File: doc/BRIEF.md
# Parallel Port Transmit Channel

This block drives a stream of samples onto a wide parallel output bus, toward a digital-to-analog converter or another parallel-port receiver. Words arrive on two valid/ready input streams, A and B. The block keeps the configured number of low data bits of each word, from 8 to 16, and clears the bits above them. It registers the result onto the output bus together with two strobes: a frame-start marker and a data-enable marker. Each strobe can be switched on or off and has its own active level.

Three transfer modes exist. Single-stream SDR sends only stream A. Interleaved SDR alternates A and B words on successive transfers in a strict order. DDR takes one A word and one B word per cycle and presents them on two output halves, one for each clock edge, which an output register at the pad merges. A receiver can throttle the channel with a wait input that has a configurable active level. While wait is active, nothing is consumed and every output holds. Configuration inputs are expected to change only while reset is held.

Top module: `ppt_tx`

## Requirements
- R1: While reset is held, q_rise and q_fall are zero, start_o is at the inverse of cfg_start_pol and en_o is at the inverse of cfg_en_pol, all observed after one clock edge.
- R2: The effective width is cfg_width clamped to the range 8..16. Bits [w-1:0] of the selected word are kept on the bus and higher bits are zero. For example, cfg_width 3 keeps 8 bits and cfg_width 20 keeps 16.
- R3: With cfg_mode 0 (single SDR; code 3 behaves the same), a_ready equals "wait not active" and b_ready is 0. An accepted A word appears on both q_rise and q_fall one cycle after the handshake.
- R4: With cfg_mode 1 (interleaved SDR), transfers alternate strictly A, B, A, B…, starting with A after reset. Only the stream whose turn it is sees ready (when wait is not active). If that stream is not valid, output stalls. Each word appears on both q_rise and q_fall.
- R5: With cfg_mode 2 (DDR), a_ready and b_ready both rise only when a_valid and b_valid are both high and wait is not active. The A word then goes to q_rise and the B word to q_fall.
- R6: In the cycle after a transfer, en_o equals cfg_en_pol when cfg_en_en is 1. When cfg_en_en is 0, en_o always stays at the inverse of cfg_en_pol.
- R7: After a cycle with no transfer and no active wait, en_o and start_o are at their inactive levels, and q_rise and q_fall keep their previous values.
- R8: Transfers (beats) are numbered from 0 after reset. A beat whose number modulo cfg_frame_len is 0 drives start_o to cfg_start_pol in the following cycle when cfg_start_en is 1; other beats drive it inactive. A frame length of 0 acts as 1, and with cfg_start_en 0 start_o stays inactive.
- R9: Wait is active when cfg_wait_en is 1 and wait_in equals cfg_wait_pol. While it is active, both readies are 0 and all four outputs hold their values into the next cycle. With cfg_wait_en 0, wait_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 single SDR, 1 interleaved SDR, 2 DDR |
| cfg_width | input | 5 | Data width request, clamped to 8..16 |
| cfg_frame_len | input | FRM_W | Beats per frame |
| cfg_start_en | input | 1 | Frame-start strobe enable |
| cfg_start_pol | input | 1 | Frame-start active level |
| cfg_en_en | input | 1 | Data-enable strobe enable |
| cfg_en_pol | input | 1 | Data-enable active level |
| cfg_wait_en | input | 1 | Wait input enable |
| cfg_wait_pol | input | 1 | Wait active level |
| a_data | input | DW | Stream A word |
| a_valid | input | 1 | Stream A valid |
| a_ready | output | 1 | Stream A ready |
| b_data | input | DW | Stream B word |
| b_valid | input | 1 | Stream B valid |
| b_ready | output | 1 | Stream B ready |
| wait_in | input | 1 | Receiver throttle |
| q_rise | output | DW | Bus word for the rising edge |
| q_fall | output | DW | Bus word for the falling edge |
| start_o | output | 1 | Frame-start strobe |
| en_o | output | 1 | Data-enable strobe |

## Verification
The assertions take for granted that configuration stays constant outside reset. They use the handshakes seen on the ports to decide when a beat took place. The bench changes configuration only while rst is high. It holds a valid word until it is accepted, and it drives wait_in either at the configured active level or at its inverse. It then compares the ordered output word sequence against the words it offered, under random valid gaps and random wait stalls, in every mode.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [1:0] {
    MODE_SDR = 2'd0,
    MODE_ILV = 2'd1,
    MODE_DDR = 2'd2
  } mode_e;
endpackage

// File: rtl/ppt_sched.sv
module ppt_sched #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  ppt_pkg::mode_e  mode,
  input  logic            wait_act,
  input  logic [DW-1:0]   a_data,
  input  logic            a_valid,
  output logic            a_ready,
  input  logic [DW-1:0]   b_data,
  input  logic            b_valid,
  output logic            b_ready,
  output logic            fire,
  output logic [DW-1:0]   w_rise,
  output logic [DW-1:0]   w_fall
);
  logic turn_b;

  always_comb begin
    a_ready = 1'b0;
    b_ready = 1'b0;
    fire    = 1'b0;
    w_rise  = a_data;
    w_fall  = a_data;
    case (mode)
      ppt_pkg::MODE_ILV: begin
        a_ready = !wait_act && !turn_b;
        b_ready = !wait_act && turn_b;
        fire    = turn_b ? (b_valid && b_ready) : (a_valid && a_ready);
        w_rise  = turn_b ? b_data : a_data;
        w_fall  = w_rise;
      end
      ppt_pkg::MODE_DDR: begin
        a_ready = !wait_act && a_valid && b_valid;
        b_ready = a_ready;
        fire    = a_ready;
        w_rise  = a_data;
        w_fall  = b_data;
      end
      default: begin
        a_ready = !wait_act;
        fire    = a_valid && a_ready;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      turn_b <= 1'b0;
    else if (mode == ppt_pkg::MODE_ILV && fire)
      turn_b <= !turn_b;
  end
endmodule

// File: rtl/ppt_frame.sv
module ppt_frame #(
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [FRM_W-1:0] frame_len,
  output logic             first
);
  logic [FRM_W-1:0] cnt;
  logic             wrap;

  assign wrap  = ({1'b0, cnt} + (FRM_W+1)'(1)) >= {1'b0, frame_len};
  assign first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (step)
      cnt <= wrap ? '0 : cnt + FRM_W'(1);
  end
endmodule

// File: rtl/ppt_drive.sv
module ppt_drive #(
  parameter int DW    = 16,
  parameter int MIN_W = 8,
  localparam int WW   = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          hold,
  input  logic          first,
  input  logic [DW-1:0] w_rise,
  input  logic [DW-1:0] w_fall,
  input  logic [WW-1:0] width,
  input  logic          start_en,
  input  logic          start_pol,
  input  logic          en_en,
  input  logic          en_pol,
  output logic [DW-1:0] q_rise,
  output logic [DW-1:0] q_fall,
  output logic          start_o,
  output logic          en_o
);
  logic [WW-1:0] eff_w;
  logic [DW-1:0] keep;

  always_comb begin
    if (width < WW'(MIN_W))
      eff_w = WW'(MIN_W);
    else if (width > WW'(DW))
      eff_w = WW'(DW);
    else
      eff_w = width;
  end

  for (genvar g = 0; g < DW; g++) begin : g_keep
    assign keep[g] = (eff_w > WW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rise  <= '0;
      q_fall  <= '0;
      start_o <= !start_pol;
      en_o    <= !en_pol;
    end else if (!hold) begin
      if (fire) begin
        q_rise  <= w_rise & keep;
        q_fall  <= w_fall & keep;
        en_o    <= en_en ? en_pol : !en_pol;
        start_o <= (start_en && first) ? start_pol : !start_pol;
      end else begin
        en_o    <= !en_pol;
        start_o <= !start_pol;
      end
    end
  end
endmodule

// File: rtl/ppt_tx.sv
module ppt_tx #(
  parameter int DW    = 16,
  parameter int FRM_W = 8,
  localparam int WW   = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [WW-1:0]    cfg_width,
  input  logic [FRM_W-1:0] cfg_frame_len,
  input  logic             cfg_start_en,
  input  logic             cfg_start_pol,
  input  logic             cfg_en_en,
  input  logic             cfg_en_pol,
  input  logic             cfg_wait_en,
  input  logic             cfg_wait_pol,
  input  logic [DW-1:0]    a_data,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [DW-1:0]    b_data,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic             wait_in,
  output logic [DW-1:0]    q_rise,
  output logic [DW-1:0]    q_fall,
  output logic             start_o,
  output logic             en_o
);
  logic          wait_act;
  logic          fire;
  logic          first;
  logic [DW-1:0] w_rise;
  logic [DW-1:0] w_fall;

  assign wait_act = cfg_wait_en && (wait_in == cfg_wait_pol);

  ppt_sched #(.DW(DW)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .mode     (ppt_pkg::mode_e'(cfg_mode)),
    .wait_act (wait_act),
    .a_data   (a_data),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .b_data   (b_data),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .fire     (fire),
    .w_rise   (w_rise),
    .w_fall   (w_fall)
  );

  ppt_frame #(.FRM_W(FRM_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .step      (fire),
    .frame_len (cfg_frame_len),
    .first     (first)
  );

  ppt_drive #(.DW(DW)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .hold      (wait_act),
    .first     (first),
    .w_rise    (w_rise),
    .w_fall    (w_fall),
    .width     (cfg_width),
    .start_en  (cfg_start_en),
    .start_pol (cfg_start_pol),
    .en_en     (cfg_en_en),
    .en_pol    (cfg_en_pol),
    .q_rise    (q_rise),
    .q_fall    (q_fall),
    .start_o   (start_o),
    .en_o      (en_o)
  );
endmodule

// File: rtl/ppt_tx_chk.sv
module ppt_tx_chk #(
  parameter int DW   = 16,
  localparam int WW  = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_mode,
  input logic [WW-1:0] cfg_width,
  input logic          cfg_en_pol,
  input logic          cfg_start_pol,
  input logic          cfg_wait_en,
  input logic          cfg_wait_pol,
  input logic          a_valid,
  input logic          a_ready,
  input logic          b_valid,
  input logic          b_ready,
  input logic          wait_in,
  input logic [DW-1:0] q_rise,
  input logic [DW-1:0] q_fall,
  input logic          start_o,
  input logic          en_o
);
  logic          wact;
  logic          xfer;
  int            ew;
  logic [DW-1:0] over;

  assign wact = cfg_wait_en && (wait_in == cfg_wait_pol);
  assign xfer = (a_valid && a_ready) || (b_valid && b_ready);
  assign ew   = (int'(cfg_width) < 8) ? 8 : ((int'(cfg_width) > DW) ? DW : int'(cfg_width));
  assign over = ~DW'((33'(1) << ew) - 33'(1));

  AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (rst)
    wact |-> (!a_ready && !b_ready)); // R9
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    wact |=> ($stable(q_rise) && $stable(q_fall) && $stable(en_o) && $stable(start_o))); // R9
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
    (!wact && !xfer) |=> (en_o == !cfg_en_pol && start_o == !cfg_start_pol)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wact && !xfer) |=> ($stable(q_rise) && $stable(q_fall))); // R7
  AST_ILV_ONE_READY: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd1) |-> $onehot0({a_ready, b_ready})); // R4
  AST_DDR_PAIRED: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd2 && a_ready) |-> (b_ready && a_valid && b_valid)); // R5
  AST_SDR_B_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0 || cfg_mode == 2'd3) |-> !b_ready); // R3
  AST_SDR_BOTH_EDGES: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode != 2'd2 && xfer) |=> (q_rise == q_fall)); // R3
  AST_WIDTH_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((q_rise & over) == '0) && ((q_fall & over) == '0)); // R2
endmodule

bind ppt_tx ppt_tx_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_mode      (cfg_mode),
  .cfg_width     (cfg_width),
  .cfg_en_pol    (cfg_en_pol),
  .cfg_start_pol (cfg_start_pol),
  .cfg_wait_en   (cfg_wait_en),
  .cfg_wait_pol  (cfg_wait_pol),
  .a_valid       (a_valid),
  .a_ready       (a_ready),
  .b_valid       (b_valid),
  .b_ready       (b_ready),
  .wait_in       (wait_in),
  .q_rise        (q_rise),
  .q_fall        (q_fall),
  .start_o       (start_o),
  .en_o          (en_o)
);

// File: tb/tb_ppt_tx.sv
module tb_ppt_tx;
  localparam int DW = 16;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_mode = '0;
  logic [4:0]    cfg_width = 5'd16;
  logic [FW-1:0] cfg_frame_len = '0;
  logic          cfg_start_en = 1'b0, cfg_start_pol = 1'b1;
  logic          cfg_en_en = 1'b0, cfg_en_pol = 1'b1;
  logic          cfg_wait_en = 1'b0, cfg_wait_pol = 1'b1;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic          a_valid = 1'b0, b_valid = 1'b0, wait_in = 1'b0;
  logic          a_ready, b_ready;
  logic [DW-1:0] q_rise, q_fall;
  logic          start_o, en_o;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] va [0:511];
  logic [DW-1:0] vb [0:511];

  always #5 clk = !clk;

  ppt_tx #(.DW(DW), .FRM_W(FW)) dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .cfg_frame_len(cfg_frame_len), .cfg_start_en(cfg_start_en),
    .cfg_start_pol(cfg_start_pol), .cfg_en_en(cfg_en_en), .cfg_en_pol(cfg_en_pol),
    .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
    .a_data(a_data), .a_valid(a_valid), .a_ready(a_ready),
    .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready),
    .wait_in(wait_in), .q_rise(q_rise), .q_fall(q_fall),
    .start_o(start_o), .en_o(en_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] keep_mask(input int w);
    int ew;
    ew = (w < 8) ? 8 : ((w > DW) ? DW : w);
    return DW'((33'(1) << ew) - 33'(1));
  endfunction

  function automatic logic [63:0] pack_out();
    return {28'd0, q_rise, q_fall, 2'd0, start_o, en_o};
  endfunction

  task automatic run_phase(input logic [1:0] mode, input logic [4:0] width, input int flen,
                           input bit st_en, input bit st_pol, input bit e_en, input bit e_pol,
                           input bit w_en, input bit w_pol, input int ncyc,
                           input int wp, input int vp);
    int ia = 0, ib = 0, k = 0, elen;
    bit turn_b = 0;
    logic [DW-1:0] m, wr, wf;
    logic [63:0] obs, expv;
    bit wact, fire, era, erb;
    string tag;
    elen = (flen == 0) ? 1 : flen;
    m = keep_mask(int'(width));
    tag = (mode == 2'd1) ? "R4" : ((mode == 2'd2) ? "R5" : "R3");
    @(negedge clk);
    rst = 1'b1; a_valid = 0; b_valid = 0; wait_in = !w_pol;
    cfg_mode = mode; cfg_width = width; cfg_frame_len = FW'(flen);
    cfg_start_en = st_en; cfg_start_pol = st_pol; cfg_en_en = e_en; cfg_en_pol = e_pol;
    cfg_wait_en = w_en; cfg_wait_pol = w_pol;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expv = {28'd0, 32'd0, 2'd0, !st_pol, !e_pol};
    check(pack_out() == expv, "R1 reset state", pack_out(), expv);
    rst = 1'b0;
    obs = pack_out();
    for (int c = 0; c < ncyc; c++) begin
      if (!a_valid) a_valid = (($urandom % 100) < vp);
      if (!b_valid) b_valid = (($urandom % 100) < vp);
      a_data = va[ia % 512];
      b_data = vb[ib % 512];
      wait_in = ((($urandom % 100) < wp) ? w_pol : !w_pol);
      if (!w_en) wait_in = $urandom % 2;
      #1;
      wact = w_en && (wait_in == w_pol);
      era = 0; erb = 0; fire = 0; wr = a_data; wf = a_data;
      if (mode == 2'd1) begin
        era = !wact && !turn_b; erb = !wact && turn_b;
        fire = turn_b ? (b_valid && erb) : (a_valid && era);
        wr = turn_b ? b_data : a_data; wf = wr;
      end else if (mode == 2'd2) begin
        era = !wact && a_valid && b_valid; erb = era; fire = era;
        wf = b_data;
      end else begin
        era = !wact; fire = a_valid && era;
      end
      check({a_ready, b_ready} == {era, erb}, {tag, "/R9 ready"},
            64'({a_ready, b_ready}), 64'({era, erb}));
      @(posedge clk);
      @(negedge clk);
      if (wact) begin
        expv = obs;
        check(pack_out() == expv, "R9 hold during wait", pack_out(), expv);
      end else if (fire) begin
        expv = {28'd0, wr & m, wf & m, 2'd0,
                (st_en && (k % elen == 0)) ? st_pol : !st_pol,
                e_en ? e_pol : !e_pol};
        check(pack_out() == expv, {tag, "/R2/R6/R8 beat"}, pack_out(), expv);
        k++;
        if (mode == 2'd1) begin
          if (turn_b) begin ib++; b_valid = 0; end else begin ia++; a_valid = 0; end
          turn_b = !turn_b;
        end else if (mode == 2'd2) begin
          ia++; ib++; a_valid = 0; b_valid = 0;
        end else begin
          ia++; a_valid = 0;
        end
      end else begin
        expv = {obs[63:4], 2'd0, !st_pol, !e_pol};
        check(pack_out() == expv, "R7 idle", pack_out(), expv);
      end
      obs = pack_out();
    end
    check(k > 0, "R6 beats seen", 64'(k), 64'(1));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) begin
      va[i] = DW'($urandom);
      vb[i] = DW'($urandom);
    end
    // mode, width, len, st_en, st_pol, e_en, e_pol, w_en, w_pol, cycles, wait%, valid%
    run_phase(2'd0, 5'd16, 4, 1, 1, 1, 1, 1, 1, 400, 20, 70);
    run_phase(2'd1, 5'd12, 5, 1, 0, 1, 0, 1, 0, 400, 25, 60);
    run_phase(2'd2, 5'd8,  3, 1, 1, 1, 0, 1, 1, 400, 15, 65);
    run_phase(2'd1, 5'd3,  0, 1, 1, 0, 1, 0, 1, 300, 50, 50);  // R2 low clamp, R8 len 0, R9 ignored wait
    run_phase(2'd2, 5'd20, 1, 0, 1, 1, 1, 1, 0, 300, 40, 80);  // R2 high clamp, start disabled
    run_phase(2'd3, 5'd10, 2, 1, 0, 1, 1, 1, 1, 200, 0, 100);  // R3 code 3, back to back
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule